// File: doc/BRIEF.md
# Dual-Threshold Excursion Event Detector

This block watches a stream of signed samples against two programmable limits, a high limit and a low limit. Each time the signal leaves the band between them, the block counts one excursion for that side. The per-side counts are running totals. They keep growing when the signal comes back inside the band, and they only drop to zero when the host reads them or when the detection window ends.

A programmable target count drives the count event. In the default mode the event fires when the two totals together reach the target. In the stricter mode the event also needs at least one excursion on each side. A window timer of programmable length runs alongside the counting. When the timer expires it flags its own event, and both totals and the timer start again from zero.

Every sample, the count event and the window expiry each set a pending status bit. The host clears a status bit by writing one to it. A single interrupt line is the OR of every pending status bit whose enable bit is set.

Top module: `band_excursion_monitor`

## Requirements
- R1: An excursion is counted once, when it begins. An upper excursion begins on a valid sample strictly greater than the high limit after a valid sample that was not. A lower excursion begins on a valid sample strictly less than the low limit after a valid sample that was not. A sample equal to a limit never counts, and further samples that stay beyond the limit add nothing.
- R2: The per-side totals are running totals. A sample back inside the band does not reset them.
- R3: Each total saturates at 2^CW-1 and does not wrap.
- R4: Address 6 reads the totals, with the upper total in bits [CW-1:0] and the lower total in bits [2CW-1:CW]. Such a read returns the values held before it and clears both totals. An excursion that begins in the same cycle as the read is counted into the cleared totals.
- R5: In the default mode (bit 16 of address 2 is 0), status bit 2 is set by any excursion start after which upper+lower >= the target count held in bits [CW:0] of address 2.
- R6: In the strict mode (bit 16 of address 2 is 1), status bit 2 needs the condition of R5 and also both totals nonzero.
- R7: After a write of W>0 to address 3, status bit 1 is set exactly W clock cycles later. At that point both totals clear and the timer restarts. W=0 stops the timer.
- R8: Every valid sample sets status bit 0.
- R9: Address 5 holds the status bits. Writing a one to a bit clears it. If a set event happens in the same cycle as the clearing write, the set wins.
- R10: irq_o is the OR of the status bits ANDed with the enable bits at address 4 (bit 0 data, bit 1 timer, bit 2 count). It rises in the same cycle as the status bit or enable that causes it, and it stays high until that cause is cleared.
- R11: Addresses 0 (high limit, sign-extended), 1 (low limit, sign-extended), 2, 3 and 4 read back the values written to them. Read data appears on the clock edge that follows the read request.
- R12: After reset all registers, totals and status bits are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DW | Signed sample |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | RW | Register write data |
| reg_rdata_o | output | RW | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
A sample, a status write or an enable write changes the status bits and irq_o on the same clock edge that captures it. Read data appears one edge after the read request. A window expiry lands exactly W edges after the window write. The bench drives every stimulus on a falling edge and samples on the falling edge that follows the edge where the result is due. For the timer it counts falling edges one by one and checks that irq_o is still low at W-1 and high at W. The sweep covers every five-excursion upper/lower pattern against every target from 0 to 6 in both modes, and checks irq_o after each excursion against an arithmetic model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [2:0] ADR_HIGH = 3'd0;
  localparam logic [2:0] ADR_LOW  = 3'd1;
  localparam logic [2:0] ADR_REQ  = 3'd2;
  localparam logic [2:0] ADR_WIN  = 3'd3;
  localparam logic [2:0] ADR_EN   = 3'd4;
  localparam logic [2:0] ADR_STAT = 3'd5;
  localparam logic [2:0] ADR_CNT  = 3'd6;

  localparam int ST_DATA  = 0;
  localparam int ST_TMR   = 1;
  localparam int ST_CNT   = 2;
  localparam int NST      = 3;
  localparam int MODE_BIT = 16;

  typedef logic [NST-1:0] st_vec_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify #(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic signed [DW-1:0] high_i,
  input  logic signed [DW-1:0] low_i,
  output logic                 up_ent_o,
  output logic                 lo_ent_o
);
  logic above, below;
  logic was_above_q, was_below_q;

  assign above    = sample_i > high_i;
  assign below    = sample_i < low_i;
  assign up_ent_o = valid_i && above && !was_above_q;
  assign lo_ent_o = valid_i && below && !was_below_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      was_above_q <= 1'b0;
      was_below_q <= 1'b0;
    end else if (valid_i) begin
      was_above_q <= above;
      was_below_q <= below;
    end
  end

  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(was_above_q && was_below_q) || (high_i < low_i)); // R1
endmodule

// File: rtl/exc_tally.sv
module exc_tally #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          up_ent_i,
  input  logic          lo_ent_i,
  input  logic          clr_i,
  input  logic [CW:0]   req_i,
  input  logic          and_mode_i,
  output logic [CW-1:0] upper_o,
  output logic [CW-1:0] lower_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] upper_q, lower_q;
  logic [CW-1:0] base_u, base_l, nxt_u, nxt_l;
  logic [CW:0]   sum;
  logic          cond;

  always_comb begin
    base_u = clr_i ? '0 : upper_q;
    base_l = clr_i ? '0 : lower_q;
    nxt_u  = (up_ent_i && base_u != CMAX) ? base_u + 1'b1 : base_u;
    nxt_l  = (lo_ent_i && base_l != CMAX) ? base_l + 1'b1 : base_l;
    sum    = {1'b0, nxt_u} + {1'b0, nxt_l};
    cond   = (sum >= req_i) && (!and_mode_i || (nxt_u != '0 && nxt_l != '0));
  end

  assign hit_o   = (up_ent_i || lo_ent_i) && cond;
  assign upper_o = upper_q;
  assign lower_o = lower_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      upper_q <= '0;
      lower_q <= '0;
    end else begin
      upper_q <= nxt_u;
      lower_q <= nxt_l;
    end
  end

  AST_TOTAL_RUNS: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> (upper_q >= $past(upper_q)) && (lower_q >= $past(lower_q))); // R2
  AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !up_ent_i) |=> $stable(upper_q)); // R1
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !up_ent_i && !lo_ent_i) |=> (upper_q == '0 && lower_q == '0)); // R4
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && upper_q == CMAX) |=> (upper_q == CMAX)); // R3
endmodule

// File: rtl/exc_window.sv
module exc_window #(
  parameter int TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [TW-1:0] win_len_i,
  input  logic          restart_i,
  output logic          expire_o
);
  logic [TW-1:0] tmr_q;

  assign expire_o = (win_len_i != '0) && (tmr_q == win_len_i - 1'b1) && !restart_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tmr_q <= '0;
    end else if (restart_i || expire_o || win_len_i == '0) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_len_i != '0) |-> (tmr_q < win_len_i)); // R7
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int TW = 24,
  parameter int RW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [RW-1:0]        reg_wdata_i,
  input  logic                 valid_i,
  input  logic                 hit_i,
  input  logic                 tmr_exp_i,
  input  logic [CW-1:0]        upper_i,
  input  logic [CW-1:0]        lower_i,
  output logic signed [DW-1:0] high_o,
  output logic signed [DW-1:0] low_o,
  output logic [CW:0]          req_o,
  output logic                 and_mode_o,
  output logic [TW-1:0]        win_o,
  output logic                 win_restart_o,
  output logic                 cnt_rd_o,
  output logic [RW-1:0]        rdata_o,
  output logic                 irq_o
);
  logic signed [DW-1:0] high_q, low_q;
  logic [CW:0]          req_q;
  logic                 and_q;
  logic [TW-1:0]        win_q;
  st_vec_t              en_q, en_d, st_q, st_d, st_set, st_w1c;
  logic [RW-1:0]        rd_d, rdata_q;
  logic                 irq_q;
  logic                 wr_stat, wr_en;
  logic                 unused_wd;

  assign unused_wd     = ^reg_wdata_i;
  assign wr_stat       = reg_we_i && reg_addr_i == ADR_STAT;
  assign wr_en         = reg_we_i && reg_addr_i == ADR_EN;
  assign win_restart_o = reg_we_i && reg_addr_i == ADR_WIN;
  assign cnt_rd_o      = reg_re_i && reg_addr_i == ADR_CNT;

  always_comb begin
    st_set          = '0;
    st_set[ST_DATA] = valid_i;
    st_set[ST_TMR]  = tmr_exp_i;
    st_set[ST_CNT]  = hit_i;
    st_w1c          = wr_stat ? reg_wdata_i[NST-1:0] : '0;
    st_d            = (st_q & ~st_w1c) | st_set;
    en_d            = wr_en ? reg_wdata_i[NST-1:0] : en_q;
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr_i)
      ADR_HIGH: rd_d = {{(RW-DW){high_q[DW-1]}}, high_q};
      ADR_LOW:  rd_d = {{(RW-DW){low_q[DW-1]}}, low_q};
      ADR_REQ: begin
        rd_d[CW:0]     = req_q;
        rd_d[MODE_BIT] = and_q;
      end
      ADR_WIN:  rd_d[TW-1:0]  = win_q;
      ADR_EN:   rd_d[NST-1:0] = en_q;
      ADR_STAT: rd_d[NST-1:0] = st_q;
      ADR_CNT:  rd_d[2*CW-1:0] = {lower_i, upper_i};
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      high_q  <= '0;
      low_q   <= '0;
      req_q   <= '0;
      and_q   <= 1'b0;
      win_q   <= '0;
      en_q    <= '0;
      st_q    <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          ADR_HIGH: high_q <= reg_wdata_i[DW-1:0];
          ADR_LOW:  low_q  <= reg_wdata_i[DW-1:0];
          ADR_REQ: begin
            req_q <= reg_wdata_i[CW:0];
            and_q <= reg_wdata_i[MODE_BIT];
          end
          ADR_WIN:  win_q <= reg_wdata_i[TW-1:0];
          default: ;
        endcase
      end
      en_q  <= en_d;
      st_q  <= st_d;
      irq_q <= |(st_d & en_d);
      if (reg_re_i) rdata_q <= rd_d;
    end
  end

  assign high_o     = high_q;
  assign low_o      = low_q;
  assign req_o      = req_q;
  assign and_mode_o = and_q;
  assign win_o      = win_q;
  assign rdata_o    = rdata_q;
  assign irq_o      = irq_q;

  AST_DATA_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> st_q[ST_DATA]); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_stat && reg_wdata_i[ST_TMR] && !tmr_exp_i) |=> !st_q[ST_TMR]); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_q && !wr_stat && !wr_en) |=> irq_q); // R10
  AST_EXPIRE_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    tmr_exp_i |=> st_q[ST_TMR]); // R7
endmodule

// File: rtl/band_excursion_monitor.sv
module band_excursion_monitor
  import exc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int TW = 24,
  parameter int RW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 smp_valid_i,
  input  logic signed [DW-1:0] smp_data_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [RW-1:0]        reg_wdata_i,
  output logic [RW-1:0]        reg_rdata_o,
  output logic                 irq_o
);
  logic signed [DW-1:0] high, low;
  logic [CW:0]          req;
  logic                 and_mode;
  logic [TW-1:0]        win;
  logic                 win_restart, cnt_rd, expire;
  logic                 up_ent, lo_ent, hit;
  logic [CW-1:0]        upper_cnt, lower_cnt;

  exc_classify #(.DW(DW)) u_cls (
    .clk_i(clk_i), .rst_i(rst_i), .valid_i(smp_valid_i), .sample_i(smp_data_i),
    .high_i(high), .low_i(low), .up_ent_o(up_ent), .lo_ent_o(lo_ent)
  );

  exc_tally #(.CW(CW)) u_tally (
    .clk_i(clk_i), .rst_i(rst_i), .up_ent_i(up_ent), .lo_ent_i(lo_ent),
    .clr_i(cnt_rd || expire), .req_i(req), .and_mode_i(and_mode),
    .upper_o(upper_cnt), .lower_o(lower_cnt), .hit_o(hit)
  );

  exc_window #(.TW(TW)) u_win (
    .clk_i(clk_i), .rst_i(rst_i), .win_len_i(win), .restart_i(win_restart),
    .expire_o(expire)
  );

  exc_regs #(.DW(DW), .CW(CW), .TW(TW), .RW(RW)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .valid_i(smp_valid_i),
    .hit_i(hit), .tmr_exp_i(expire), .upper_i(upper_cnt), .lower_i(lower_cnt),
    .high_o(high), .low_o(low), .req_o(req), .and_mode_o(and_mode), .win_o(win),
    .win_restart_o(win_restart), .cnt_rd_o(cnt_rd), .rdata_o(reg_rdata_o),
    .irq_o(irq_o)
  );
endmodule

// File: tb/sim_band_excursion_monitor.sv
module sim_band_excursion_monitor;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int TW = 8;
  localparam int RW = 32;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 valid = 1'b0;
  logic signed [DW-1:0] data = '0;
  logic                 we = 1'b0;
  logic                 re = 1'b0;
  logic [2:0]           addr = '0;
  logic [RW-1:0]        wdata = '0;
  logic [RW-1:0]        rdata;
  logic                 irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  band_excursion_monitor #(.DW(DW), .CW(CW), .TW(TW), .RW(RW)) u0 (
    .clk_i(clk), .rst_i(rst), .smp_valid_i(valid), .smp_data_i(data),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [RW-1:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    @(posedge clk); @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic smp(input int d);
    @(negedge clk); valid = 1'b1; data = DW'(d);
    @(posedge clk); @(negedge clk); valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    int u, l;
    bit pend, cond;

    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R12: reset state
    chk(irq == 1'b0, "R12", irq, 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R12", v, 0);
    end

    // R11: readback
    wr(3'd0, 32'hFFFF_FFFB); rd(3'd0, v); chk(v == 32'hFFFF_FFFB, "R11", v, 32'hFFFF_FFFB);
    wr(3'd1, 32'd7);         rd(3'd1, v); chk(v == 7, "R11", v, 7);
    wr(3'd2, 32'h0001_0005); rd(3'd2, v); chk(v == 32'h0001_0005, "R11", v, 32'h0001_0005);
    wr(3'd3, 32'd9);         rd(3'd3, v); chk(v == 9, "R11", v, 9);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd7);         rd(3'd4, v); chk(v == 7, "R11", v, 7);

    // working limits: high 20, low -20
    wr(3'd0, 32'd20);
    wr(3'd1, 32'hFFFF_FFEC);
    wr(3'd4, 32'd0);
    rd(3'd6, v);
    wr(3'd5, 32'd7);

    // R1: equality does not count, staying beyond counts once
    smp(20); smp(0); smp(-20); smp(0);
    rd(3'd6, v); chk(v == 0, "R1", v, 0);
    smp(21); smp(22); smp(60); smp(0); smp(-21); smp(-50); smp(0);
    rd(3'd6, v); chk(v == 9, "R1", v, 9);

    // R3: saturation
    for (int k = 0; k < 9; k++) begin smp(50); smp(0); end
    rd(3'd6, v); chk(v == 7, "R3", v, 7);
    for (int k = 0; k < 9; k++) begin smp(-50); smp(0); end
    rd(3'd6, v); chk(v == 56, "R3", v, 56);

    // R4: read clears, entry in the read cycle survives
    smp(50); smp(0);
    @(negedge clk); re = 1'b1; addr = 3'd6; valid = 1'b1; data = -50;
    @(posedge clk); @(negedge clk); re = 1'b0; valid = 1'b0;
    chk(rdata == 1, "R4", rdata, 1);
    smp(0);
    rd(3'd6, v); chk(v == 8, "R4", v, 8);
    rd(3'd6, v); chk(v == 0, "R4", v, 0);

    // R5 R6 R2: sweep of excursion patterns, targets and modes
    wr(3'd4, 32'd4);
    for (int mode = 0; mode < 2; mode++) begin
      for (int req = 0; req < 7; req++) begin
        for (int p = 0; p < 32; p++) begin
          wr(3'd2, (RW'(mode) << 16) | RW'(req));
          rd(3'd6, v);
          wr(3'd5, 32'd7);
          chk(irq == 1'b0, mode ? "R6" : "R5", irq, 0);
          u = 0; l = 0; pend = 1'b0;
          for (int k = 0; k < 5; k++) begin
            if (p[k]) begin smp(50); u++; end
            else begin smp(-50); l++; end
            cond = (u + l >= req) && (mode == 0 || (u != 0 && l != 0));
            if (cond) pend = 1'b1;
            chk(irq == pend, mode ? "R6" : "R5", irq, pend);
            smp(0);
          end
          rd(3'd6, v);
          chk(v == RW'(l * 8 + u), "R2", v, l * 8 + u);
        end
      end
    end

    // R7: window expiry timing and count restart
    wr(3'd2, 32'd7);
    wr(3'd4, 32'd2);
    rd(3'd6, v);
    wr(3'd5, 32'd7);
    smp(50); smp(0); smp(50); smp(0);
    wr(3'd3, 32'd12);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k < 12) chk(irq == 1'b0, "R7", irq, 0);
      else        chk(irq == 1'b1, "R7", irq, 1);
    end
    wr(3'd3, 32'd0);
    rd(3'd6, v); chk(v == 0, "R7", v, 0);

    // R8: data-ready
    wr(3'd4, 32'd1);
    wr(3'd5, 32'd7);
    chk(irq == 1'b0, "R8", irq, 0);
    smp(0);
    chk(irq == 1'b1, "R8", irq, 1);

    // R9: W1C and set-wins
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd7);
    rd(3'd5, v); chk(v == 0, "R9", v, 0);
    @(negedge clk); we = 1'b1; addr = 3'd5; wdata = 32'd1; valid = 1'b1; data = 0;
    @(posedge clk); @(negedge clk); we = 1'b0; valid = 1'b0;
    rd(3'd5, v); chk(v == 1, "R9", v, 1);

    // R10: enable gating and hold
    wr(3'd2, 32'd1);
    wr(3'd5, 32'd7);
    smp(50); smp(0);
    chk(irq == 1'b0, "R10", irq, 0);
    wr(3'd4, 32'd4);
    chk(irq == 1'b1, "R10", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10", irq, 1);
    wr(3'd5, 32'd4);
    chk(irq == 1'b0, "R10", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule